// File: doc/BRIEF.md
# Decode-Resolved Branch Hazard and Forwarding Controller

This block holds the stall, flush and operand-bypass decisions for a five-stage load/store pipeline in which conditional compare-with-zero branches settle in the decode stage. It is purely combinational. Each cycle it reads the register fields and write/load flags of the instructions in decode, execute, memory and writeback, together with the comparator's taken result. From these it drives a hold for the program counter and the fetch/decode register, a bubble for the decode/execute register, a clear for the fetch/decode register, and three bypass selects.

Two of the selects feed the ALU operands in execute. The third feeds the zero-comparator in decode. The comparator test needs a value earlier than the ALU does. A producer directly ahead of a branch therefore costs one held cycle if it is an ALU operation, and two held cycles if it is a load. The held branch then takes the value from a later stage through the comparator bypass.

Register 31 is the constant-zero register. It never produces a bypass and never causes a hold.

Top module: `hz_branch_id_ctrl`

## Requirements
- R1: An ALU operand select is 2'b10 (take the memory-stage result) when the memory-stage instruction writes a register, its destination is not 31, and its destination equals that operand's register.
- R2: Otherwise the select is 2'b01 (take the writeback result) when the writeback instruction writes a non-31 destination equal to the operand; in all other cases it is 2'b00 (register file). The memory-stage result wins when both stages match.
- R3: Destination 31 never yields a nonzero select and never causes a hold; with all stages idle (no writes, no loads, no branch) every output is 0.
- R4: A load in execute (write and load flags set, destination not 31) whose destination equals a decode source that is marked as used (first or second source) raises the hold.
- R5: A branch in decode whose tested register equals the non-31 destination of a writing instruction in execute raises the hold. An ALU producer therefore costs exactly one held cycle.
- R6: A branch in decode also holds while a load writing its tested register sits in the memory stage. A load directly ahead therefore costs exactly two held cycles.
- R7: The comparator select is 2'b10 when a non-load memory-stage instruction writes the tested register (not 31). It is 2'b01 when the writeback instruction writes it and the memory stage does not. It is 2'b00 otherwise.
- R8: Whenever the hold is raised, the decode/execute bubble is raised in the same cycle, and only then.
- R9: The fetch/decode clear is high exactly when decode holds a branch, the branch is taken, and no hold is raised.
- R10: In a counting loop of N=4 passes (immediate add, decrement, branch-if-nonzero back), the run shows 4 held cycles and 3 clears. With a load producing the tested register instead of the decrement, it shows 8 held cycles and 3 clears. The resolving branch selects 2'b10 and 2'b01 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_is_cbr | input | 1 | Decode holds a conditional branch |
| id_br_taken | input | 1 | Comparator result for the decode branch |
| id_use_rn | input | 1 | Decode instruction reads its first source |
| id_use_rm | input | 1 | Decode instruction reads its second source |
| id_rn | input | REG_W | Decode first source register |
| id_rm | input | REG_W | Decode second source register |
| id_rt | input | REG_W | Register tested by the decode branch |
| ex_rn | input | REG_W | Execute first source register |
| ex_rm | input | REG_W | Execute second source register |
| ex_rd | input | REG_W | Execute destination |
| ex_regwrite | input | 1 | Execute instruction writes a register |
| ex_memread | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Memory-stage destination |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_memread | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_W | Writeback destination |
| wb_regwrite | input | 1 | Writeback instruction writes a register |
| hold_fetch | output | 1 | Freeze program counter and fetch/decode register |
| bubble_idex | output | 1 | Zero the control bits entering execute |
| flush_ifid | output | 1 | Clear the fetch/decode register |
| fwd_alu_a | output | 2 | First ALU operand bypass select |
| fwd_alu_b | output | 2 | Second ALU operand bypass select |
| fwd_cmp | output | 2 | Decode comparator bypass select |

## Verification
Several properties are checked by the assertions in every evaluation. Hold and bubble always agree, and a clear never coincides with a hold. A select of 2'b10 or 2'b01 only ever names a writing, non-31 producer. A hold caused by a load really has a load behind it. Only the bench's pipeline scenarios can show the timing: one held cycle after an ALU producer, two after a load, and the single cleared slot per taken pass, which arise from the block's outputs fed back through a modelled pipeline over many cycles.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick #(
  parameter int   REG_W         = 5,
  parameter logic SKIP_MEM_LOAD = 1'b0
) (
  input  logic [REG_W-1:0] src,
  input  logic             mem_we,
  input  logic             mem_ld,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             wb_we,
  input  logic [REG_W-1:0] wb_rd,
  output hz_pkg::fwd_e     sel
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  function automatic logic produces(input logic we, input logic [REG_W-1:0] dst,
                                    input logic [REG_W-1:0] want);
    return we && (dst != ZERO_REG) && (dst == want);
  endfunction

  logic mem_hit;
  logic mem_ok;
  logic wb_hit;

  assign mem_hit = produces(mem_we, mem_rd, src);
  assign mem_ok  = mem_hit && !(SKIP_MEM_LOAD && mem_ld);
  assign wb_hit  = produces(wb_we, wb_rd, src) && !mem_hit;

  always_comb begin
    if (mem_ok)      sel = hz_pkg::FWD_MEM;
    else if (wb_hit) sel = hz_pkg::FWD_WB;
    else             sel = hz_pkg::FWD_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W = 5
) (
  input  logic             ex_we,
  input  logic             ex_ld,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             use_rn,
  input  logic             use_rm,
  input  logic [REG_W-1:0] id_rn,
  input  logic [REG_W-1:0] id_rm,
  output logic             stall
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  function automatic logic waits_on(input logic used, input logic [REG_W-1:0] s,
                                    input logic [REG_W-1:0] d);
    return used && (s == d) && (d != ZERO_REG);
  endfunction

  logic load_live;
  assign load_live = ex_we && ex_ld;
  assign stall = load_live &&
                 (waits_on(use_rn, id_rn, ex_rd) || waits_on(use_rm, id_rm, ex_rd));
endmodule

// File: rtl/hz_branch_stall.sv
module hz_branch_stall #(
  parameter int REG_W = 5
) (
  input  logic             is_cbr,
  input  logic [REG_W-1:0] rt,
  input  logic             ex_we,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_we,
  input  logic             mem_ld,
  input  logic [REG_W-1:0] mem_rd,
  output logic             stall_ex,
  output logic             stall_memld
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  function automatic logic writes_rt(input logic we, input logic [REG_W-1:0] d,
                                     input logic [REG_W-1:0] t);
    return we && (d != ZERO_REG) && (d == t);
  endfunction

  assign stall_ex    = is_cbr && writes_rt(ex_we, ex_rd, rt);
  assign stall_memld = is_cbr && mem_ld && writes_rt(mem_we, mem_rd, rt);
endmodule

// File: rtl/hz_branch_id_ctrl.sv
module hz_branch_id_ctrl #(
  parameter int REG_W = 5
) (
  input  logic             id_is_cbr,
  input  logic             id_br_taken,
  input  logic             id_use_rn,
  input  logic             id_use_rm,
  input  logic [REG_W-1:0] id_rn,
  input  logic [REG_W-1:0] id_rm,
  input  logic [REG_W-1:0] id_rt,
  input  logic [REG_W-1:0] ex_rn,
  input  logic [REG_W-1:0] ex_rm,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_regwrite,
  input  logic             ex_memread,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_regwrite,
  input  logic             mem_memread,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_regwrite,
  output logic             hold_fetch,
  output logic             bubble_idex,
  output logic             flush_ifid,
  output logic [1:0]       fwd_alu_a,
  output logic [1:0]       fwd_alu_b,
  output logic [1:0]       fwd_cmp
);
  localparam int N_OPND = 2;

  logic [N_OPND-1:0][REG_W-1:0] ex_src;
  hz_pkg::fwd_e                 opnd_sel [N_OPND];
  hz_pkg::fwd_e                 cmp_sel;

  logic lu_stall;
  logic br_stall_ex;
  logic br_stall_memld;
  logic stall_any;

  assign ex_src[0] = ex_rn;
  assign ex_src[1] = ex_rm;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    hz_fwd_pick #(.REG_W(REG_W), .SKIP_MEM_LOAD(1'b0)) u_pick (
      .src   (ex_src[g]),
      .mem_we(mem_regwrite),
      .mem_ld(mem_memread),
      .mem_rd(mem_rd),
      .wb_we (wb_regwrite),
      .wb_rd (wb_rd),
      .sel   (opnd_sel[g])
    );
  end

  hz_fwd_pick #(.REG_W(REG_W), .SKIP_MEM_LOAD(1'b1)) u_cmp_pick (
    .src   (id_rt),
    .mem_we(mem_regwrite),
    .mem_ld(mem_memread),
    .mem_rd(mem_rd),
    .wb_we (wb_regwrite),
    .wb_rd (wb_rd),
    .sel   (cmp_sel)
  );

  hz_load_use #(.REG_W(REG_W)) u_lu (
    .ex_we (ex_regwrite),
    .ex_ld (ex_memread),
    .ex_rd (ex_rd),
    .use_rn(id_use_rn),
    .use_rm(id_use_rm),
    .id_rn (id_rn),
    .id_rm (id_rm),
    .stall (lu_stall)
  );

  hz_branch_stall #(.REG_W(REG_W)) u_bs (
    .is_cbr     (id_is_cbr),
    .rt         (id_rt),
    .ex_we      (ex_regwrite),
    .ex_rd      (ex_rd),
    .mem_we     (mem_regwrite),
    .mem_ld     (mem_memread),
    .mem_rd     (mem_rd),
    .stall_ex   (br_stall_ex),
    .stall_memld(br_stall_memld)
  );

  assign stall_any   = lu_stall || br_stall_ex || br_stall_memld;
  assign hold_fetch  = stall_any;
  assign bubble_idex = stall_any;
  assign flush_ifid  = id_is_cbr && id_br_taken && !stall_any;
  assign fwd_alu_a   = opnd_sel[0];
  assign fwd_alu_b   = opnd_sel[1];
  assign fwd_cmp     = cmp_sel;
endmodule

// File: rtl/hz_branch_id_chk.sv
module hz_branch_id_chk #(
  parameter int REG_W = 5
) (
  input logic             id_is_cbr,
  input logic [REG_W-1:0] id_rt,
  input logic [REG_W-1:0] ex_rn,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_memread,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_regwrite,
  input logic             mem_memread,
  input logic [REG_W-1:0] wb_rd,
  input logic             wb_regwrite,
  input logic             hold_fetch,
  input logic             bubble_idex,
  input logic             flush_ifid,
  input logic [1:0]       fwd_alu_a,
  input logic [1:0]       fwd_alu_b,
  input logic [1:0]       fwd_cmp,
  input logic             lu_stall,
  input logic             br_stall_ex,
  input logic             br_stall_memld
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  always_comb begin
    assert_hold_bubble_R8: assert (hold_fetch == bubble_idex)
      else $error("hold and bubble disagree");
    assert_flush_not_held_R9: assert (!(flush_ifid && hold_fetch))
      else $error("clear during hold");
    assert_mem_src_valid_R1: assert (fwd_alu_a != 2'b10 || (mem_regwrite && mem_rd != ZERO_REG && mem_rd == ex_rn))
      else $error("bad memory bypass on operand a");
    assert_wb_src_valid_R2: assert (fwd_alu_b != 2'b01 || (wb_regwrite && wb_rd != ZERO_REG))
      else $error("bad writeback bypass on operand b");
    assert_no_illegal_sel_R3: assert (fwd_alu_a != 2'b11 && fwd_alu_b != 2'b11 && fwd_cmp != 2'b11)
      else $error("illegal select code");
    assert_lu_needs_load_R4: assert (!lu_stall || (ex_memread && ex_rd != ZERO_REG))
      else $error("load-use hold without a load");
    assert_br_ex_needs_branch_R5: assert (!br_stall_ex || (id_is_cbr && ex_rd == id_rt))
      else $error("branch hold without dependency");
    assert_br_memld_needs_load_R6: assert (!br_stall_memld || (mem_memread && hold_fetch))
      else $error("memory-load branch hold inconsistent");
    assert_cmp_not_from_load_R7: assert (fwd_cmp != 2'b10 || !mem_memread)
      else $error("comparator bypass from unfinished load");
  end
endmodule

bind hz_branch_id_ctrl hz_branch_id_chk #(.REG_W(REG_W)) u_chk (
  .id_is_cbr     (id_is_cbr),
  .id_rt         (id_rt),
  .ex_rn         (ex_rn),
  .ex_rd         (ex_rd),
  .ex_memread    (ex_memread),
  .mem_rd        (mem_rd),
  .mem_regwrite  (mem_regwrite),
  .mem_memread   (mem_memread),
  .wb_rd         (wb_rd),
  .wb_regwrite   (wb_regwrite),
  .hold_fetch    (hold_fetch),
  .bubble_idex   (bubble_idex),
  .flush_ifid    (flush_ifid),
  .fwd_alu_a     (fwd_alu_a),
  .fwd_alu_b     (fwd_alu_b),
  .fwd_cmp       (fwd_cmp),
  .lu_stall      (lu_stall),
  .br_stall_ex   (br_stall_ex),
  .br_stall_memld(br_stall_memld)
);

// File: tb/hz_branch_id_ctrl_tb.sv
module hz_branch_id_ctrl_tb;
  typedef struct packed {
    logic       we;
    logic       ld;
    logic       br;
    logic       urn;
    logic       urm;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [4:0] rm;
    logic [4:0] rt;
    logic [7:0] tgt;
  } ins_t;

  localparam ins_t NOP = '{rd: 5'd31, rn: 5'd31, rm: 5'd31, rt: 5'd31, default: '0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  ins_t s_id = NOP, s_ex = NOP, s_mem = NOP, s_wb = NOP;
  logic taken = 1'b0;
  int checks = 0, errors = 0;

  logic hold, bubble, flush;
  logic [1:0] fa, fb, fc;

  hz_branch_id_ctrl #(.REG_W(5)) u_dut (
    .id_is_cbr(s_id.br), .id_br_taken(taken), .id_use_rn(s_id.urn), .id_use_rm(s_id.urm),
    .id_rn(s_id.rn), .id_rm(s_id.rm), .id_rt(s_id.rt),
    .ex_rn(s_ex.rn), .ex_rm(s_ex.rm), .ex_rd(s_ex.rd),
    .ex_regwrite(s_ex.we), .ex_memread(s_ex.ld),
    .mem_rd(s_mem.rd), .mem_regwrite(s_mem.we), .mem_memread(s_mem.ld),
    .wb_rd(s_wb.rd), .wb_regwrite(s_wb.we),
    .hold_fetch(hold), .bubble_idex(bubble), .flush_ifid(flush),
    .fwd_alu_a(fa), .fwd_alu_b(fb), .fwd_cmp(fc)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit live(input logic we, input logic [4:0] d, input logic [4:0] s);
    return (we == 1'b1) && (d == s) && (d != 5'd31);
  endfunction

  function automatic int exp_sel(input logic [4:0] s);
    if (live(s_mem.we, s_mem.rd, s)) return 2;
    if (live(s_wb.we, s_wb.rd, s)) return 1;
    return 0;
  endfunction

  function automatic int exp_cmp();
    if (live(s_mem.we, s_mem.rd, s_id.rt)) return s_mem.ld ? 0 : 2;
    if (live(s_wb.we, s_wb.rd, s_id.rt)) return 1;
    return 0;
  endfunction

  function automatic bit exp_stall();
    bit lu, be, bm;
    lu = s_ex.we && s_ex.ld &&
         ((s_id.urn && live(1'b1, s_ex.rd, s_id.rn)) || (s_id.urm && live(1'b1, s_ex.rd, s_id.rm)));
    be = s_id.br && live(s_ex.we, s_ex.rd, s_id.rt);
    bm = s_id.br && s_mem.ld && live(s_mem.we, s_mem.rd, s_id.rt);
    return lu || be || bm;
  endfunction

  task automatic check_all(input string tag);
    bit st;
    st = exp_stall();
    chk({tag, " R1/R2 a"}, fa, exp_sel(s_ex.rn));
    chk({tag, " R1/R2 b"}, fb, exp_sel(s_ex.rm));
    chk({tag, " R7 cmp"}, fc, exp_cmp());
    chk({tag, " R4 hold"}, hold, st);
    chk({tag, " R8 bubble"}, bubble, st);
    chk({tag, " R9 flush"}, flush, s_id.br && taken && !st);
  endtask

  function automatic logic [4:0] pick_reg();
    int unsigned k;
    k = $urandom % 5;
    return (k == 4) ? 5'd31 : 5'(k);
  endfunction

  function automatic ins_t rnd_ins();
    ins_t x;
    x.we = 1'($urandom); x.ld = 1'($urandom); x.br = 1'($urandom);
    x.urn = 1'($urandom); x.urm = 1'($urandom);
    x.rd = pick_reg(); x.rn = pick_reg(); x.rm = pick_reg(); x.rt = pick_reg();
    x.tgt = '0;
    return x;
  endfunction

  function automatic ins_t mk(input logic we, input logic ld, input logic br,
                              input logic [4:0] rd, input logic [4:0] rn,
                              input logic [4:0] rm, input logic [4:0] rt, input logic [7:0] tgt);
    ins_t x;
    x.we = we; x.ld = ld; x.br = br; x.rd = rd; x.rn = rn; x.rm = rm; x.rt = rt; x.tgt = tgt;
    x.urn = !br && rn != 5'd31; x.urm = !br && rm != 5'd31;
    return x;
  endfunction

  function automatic ins_t fetch(input int pc, input bit use_load);
    case (pc)
      0: return mk(1, 0, 0, 5'd1, 5'd31, 5'd31, 5'd31, 0);
      1: return mk(1, 0, 0, 5'd2, 5'd2, 5'd31, 5'd31, 0);
      2: return mk(1, use_load, 0, 5'd1, 5'd1, 5'd31, 5'd31, 0);
      3: return mk(0, 0, 1, 5'd31, 5'd31, 5'd31, 5'd1, 8'd1);
      4: return mk(1, 0, 0, 5'd8, 5'd5, 5'd31, 5'd31, 0);
      default: return NOP;
    endcase
  endfunction

  task automatic run_loop(input bit use_load, input int n_pass, input int exp_stalls,
                          input int exp_flushes, input int exp_c);
    int pc, brc, stalls, flushes;
    pc = 0; brc = 0; stalls = 0; flushes = 0;
    s_id = NOP; s_ex = NOP; s_mem = NOP; s_wb = NOP; taken = 1'b0;
    for (int cyc = 0; cyc < 60; cyc++) begin
      @(negedge clk);
      if (s_id.br && !hold) chk(use_load ? "R10 load cmp sel" : "R10 alu cmp sel", fc, exp_c);
      stalls += int'(hold);
      flushes += int'(flush);
      s_wb = s_mem;
      s_mem = s_ex;
      if (hold) begin
        s_ex = NOP;
      end else begin
        s_ex = s_id;
        if (s_id.br) brc++;
        if (taken) begin
          pc = int'(s_id.tgt);
          s_id = NOP;
        end else begin
          s_id = fetch(pc, use_load);
          pc++;
        end
      end
      taken = s_id.br && (brc < n_pass - 1);
    end
    chk(use_load ? "R6/R10 load stalls" : "R5/R10 alu stalls", stalls, exp_stalls);
    chk("R9/R10 flushes", flushes, exp_flushes);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    chk("R3 idle hold", hold, 0);
    chk("R3 idle flush", flush, 0);
    chk("R3 idle sel", {fa, fb, fc}, 0);
    rst_n = 1'b1;

    // R2 priority: both stages produce X3 for operand a
    @(negedge clk);
    s_ex = mk(1, 0, 0, 5'd9, 5'd3, 5'd4, 5'd31, 0);
    s_mem = mk(1, 0, 0, 5'd3, 5'd31, 5'd31, 5'd31, 0);
    s_wb = mk(1, 0, 0, 5'd3, 5'd31, 5'd31, 5'd31, 0);
    #1 chk("R2 newer wins", fa, 2);
    s_mem.rd = 5'd7;
    #1 chk("R2 wb bypass", fa, 1);
    // R3: load into register 31 ahead of a reader of 31
    s_ex = mk(1, 1, 0, 5'd31, 5'd1, 5'd31, 5'd31, 0);
    s_id = mk(1, 0, 0, 5'd2, 5'd31, 5'd31, 5'd31, 0);
    s_id.urn = 1'b1;
    #1 chk("R3 zero reg no hold", hold, 0);
    // R4: load-use on second operand
    s_ex.rd = 5'd6;
    s_id.urm = 1'b1; s_id.rm = 5'd6;
    #1 chk("R4 load-use hold", hold, 1);
    // R9: taken branch with no hazard clears
    s_ex = NOP; s_mem = NOP; s_wb = NOP;
    s_id = mk(0, 0, 1, 5'd31, 5'd31, 5'd31, 5'd4, 1);
    taken = 1'b1;
    #1 chk("R9 clear on taken", flush, 1);
    taken = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      s_id = rnd_ins(); s_ex = rnd_ins(); s_mem = rnd_ins(); s_wb = rnd_ins();
      taken = 1'($urandom);
      #1 check_all("rand");
    end

    run_loop(1'b0, 4, 4, 3, 2);
    run_loop(1'b1, 4, 8, 3, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule